// File: doc/BRIEF.md
# Saturating Receive Discard Counter

This block counts dropped receive packets for each channel of a receive datapath. Every channel owns two 16-bit counters. The first is a general discard tally. Four separate drop-reason strobes feed it: the input port stage, the flow lookup stage, a full completion ring, and an empty prefetch buffer for receive blocks. The second counts only the drops made by the weighted random early discard stage. A counter that reaches all-ones holds there instead of wrapping. A sticky overflow flag then records that at least one event was lost.

Software reaches the counters through a small register port. A channel index and a counter select pick one counter. A read returns the count and the overflow flag one cycle later. Writing an all-zero word to a counter clears both its count and its flag. Because the read samples the state before any clear made in the same cycle, a driver can read and clear in one cycle without losing events.

Top module: `rx_drop_tally`

## Requirements
- R1: After reset every count is 0, every overflow flag is 0 and rd_valid is low.
- R2: A count that reaches 0xFFFF stays at 0xFFFF for any further events; it never wraps.
- R3: The overflow flag sets when an update would take the count above 0xFFFF and then stays set. Landing exactly on 0xFFFF does not set it.
- R4: Channel c's general counter adds, each cycle, the number of asserted bits in misc_evt[4c+3:4c]. Bit 0 is the input port drop, bit 1 the lookup drop, bit 2 the full completion ring and bit 3 the empty prefetch buffer.
- R5: Channel c's early-discard counter adds 1 for each cycle in which wred_evt[c] is high. General strobes never change it, and early-discard strobes never change the general counter.
- R6: Each channel's counters are independent. reg_ch selects the channel; reg_sel=0 selects the general counter and reg_sel=1 the early-discard counter.
- R7: A write (wr_en) of wr_data equal to zero clears the selected count and overflow flag. Events in that same cycle leave the count equal to the number of those events.
- R8: A write with nonzero wr_data changes no counter.
- R9: rd_valid is high exactly one cycle after rd_en. rd_data[15:0] is the count and rd_data[16] the overflow flag, both as they stood before that rd_en cycle's updates. A read in the same cycle as a clear therefore returns the pre-clear value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| misc_evt | input | 16 | Four drop-reason strobes per channel, channel c at bits 4c+3:4c |
| wred_evt | input | 4 | Early-discard strobe, one per channel |
| rd_en | input | 1 | Register read request |
| wr_en | input | 1 | Register write request |
| reg_ch | input | 2 | Channel index for read or write |
| reg_sel | input | 1 | Counter select: 0 general, 1 early discard |
| wr_data | input | 17 | Write word; all-zero clears the selected counter |
| rd_data | output | 17 | Overflow flag in bit 16, count in bits 15:0 |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The bench fills one counter to three below the maximum, then lands it exactly on 0xFFFF and pushes one event past it. A design that wraps would read back a small count. A design that flags overflow too early would report the flag at exactly 0xFFFF. A clear with strobes firing in the same cycle, and a read issued together with a clear, expose a design that drops the concurrent events or returns post-clear data. Strobes on one channel or counter type, with reads of all the others, catch crossed decoding. A nonzero write followed by a read catches a clear that ignores the data word.

// File: rtl/rxd_pkg.sv
// Shared definitions for the receive discard counter.
// Assumes: the counter select is one bit wide.
package rxd_pkg;
    // Counter type selected on the register port.
    typedef enum logic {
        CTR_GENERAL = 1'b0,
        CTR_EARLY   = 1'b1
    } ctr_sel_e;

    // Number of counter types per channel.
    localparam int CTR_PER_CH = 2;
endpackage

// File: rtl/rxd_strobe_sum.sv
// Counts how many of N strobes are asserted in the current cycle.
// Assumes: N >= 1; the result is purely combinational.
module rxd_strobe_sum #(
    parameter int N     = 4,
    parameter int SUM_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     strobes,
    output logic [SUM_W-1:0] total
);
    // Add up the asserted strobes.
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + SUM_W'(strobes[i]);
        end
    end
endmodule

// File: rtl/rxd_sat_counter.sv
// One saturating event counter with a sticky overflow flag.
// Adds inc each cycle, holds at all-ones, and sets ovf when an update
// would pass all-ones. clr restarts from zero, and inc still applies.
// Assumes: INC_W < CNT_W.
module rxd_sat_counter #(
    parameter int CNT_W = 16,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W:0]   TOP_EXT = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W-1:0] TOP     = {CNT_W{1'b1}};

    logic [CNT_W:0]   base;
    logic [CNT_W:0]   sum;
    logic             past_top;
    logic [CNT_W-1:0] cnt_nx;
    logic             ovf_nx;

    // Pick the starting value, add the increment and clamp.
    always_comb begin
        base     = clr ? '0 : {1'b0, cnt};
        sum      = base + (CNT_W + 1)'(inc);
        past_top = (sum > TOP_EXT);
        cnt_nx   = past_top ? TOP : sum[CNT_W-1:0];
        ovf_nx   = (ovf & ~clr) | past_top;
    end

    // Register count and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            cnt <= cnt_nx;
            ovf <= ovf_nx;
        end
    end

    // R2: a saturated count holds unless cleared.
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && !clr) |=> (cnt == TOP));

    // R3: overflow flag is sticky until a clear.
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    // R3: the flag only appears while the count sits at the top.
    p_ovf_at_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf)) |-> (cnt == TOP));

    // R7: a clear leaves exactly the same-cycle event count and no flag.
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == CNT_W'($past(inc)) && !ovf));

    // R4: below the top the count advances by exactly the increment.
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt != TOP && !ovf) |=>
            (cnt >= $past(cnt)) && (cnt - $past(cnt) <= CNT_W'($past(inc))));
endmodule

// File: rtl/rxd_read_port.sv
// Registered read mux across all counters.
// Returns {flag, count} one cycle after rd_en, sampling state before
// that cycle's updates. Assumes counters are ordered channel-major,
// with the type select as the low index bit.
module rxd_read_port #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int NCTR   = NUM_CH * rxd_pkg::CTR_PER_CH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [CH_W-1:0]       rd_ch,
    input  logic                  rd_sel,
    input  logic [NCTR*CNT_W-1:0] cnt_flat,
    input  logic [NCTR-1:0]       ovf_flat,
    output logic [CNT_W:0]        rd_data,
    output logic                  rd_valid
);
    localparam int IDX_W = CH_W + 1;

    logic [IDX_W-1:0] idx;

    // Form the counter index from channel and select.
    always_comb idx = {rd_ch, rd_sel};

    // Capture the selected counter on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= {ovf_flat[idx], cnt_flat[idx*CNT_W +: CNT_W]};
            end
        end
    end

    // R9: valid follows a read by exactly one cycle.
    p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

// File: rtl/rx_drop_tally.sv
// Per-channel receive discard counters: a general counter fed by
// N_CAUSE drop-reason strobes, and an early-discard counter, for each
// channel. Counters saturate with a sticky overflow flag. An all-zero
// register write clears one counter; reads return {flag, count} after
// one cycle. Assumes strobes are single-cycle pulses synchronous to clk.
module rx_drop_tally #(
    parameter int NUM_CH  = 4,
    parameter int N_CAUSE = 4,
    parameter int CNT_W   = 16,
    parameter int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH*N_CAUSE-1:0] misc_evt,
    input  logic [NUM_CH-1:0]         wred_evt,
    input  logic                      rd_en,
    input  logic                      wr_en,
    input  logic [CH_W-1:0]           reg_ch,
    input  logic                      reg_sel,
    input  logic [CNT_W:0]            wr_data,
    output logic [CNT_W:0]            rd_data,
    output logic                      rd_valid
);
    import rxd_pkg::*;

    localparam int NCTR   = NUM_CH * CTR_PER_CH;
    localparam int GEN_IW = $clog2(N_CAUSE + 1);
    localparam int EAR_IW = 1;

    logic [NCTR*CNT_W-1:0] cnt_flat;
    logic [NCTR-1:0]       ovf_flat;
    logic                  clear_req;

    // A write clears only when the whole word is zero.
    always_comb clear_req = wr_en && (wr_data == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [GEN_IW-1:0] gen_inc;
        logic [EAR_IW-1:0] ear_inc;
        logic              hit_ch;
        logic              gen_clr;
        logic              ear_clr;

        // Decode the clear for this channel's two counters.
        always_comb begin
            hit_ch  = clear_req && (reg_ch == CH_W'(c));
            gen_clr = hit_ch && (ctr_sel_e'(reg_sel) == CTR_GENERAL);
            ear_clr = hit_ch && (ctr_sel_e'(reg_sel) == CTR_EARLY);
        end

        rxd_strobe_sum #(.N(N_CAUSE), .SUM_W(GEN_IW)) u_gen_sum (
            .strobes (misc_evt[c*N_CAUSE +: N_CAUSE]),
            .total   (gen_inc)
        );

        rxd_strobe_sum #(.N(1), .SUM_W(EAR_IW)) u_ear_sum (
            .strobes (wred_evt[c]),
            .total   (ear_inc)
        );

        rxd_sat_counter #(.CNT_W(CNT_W), .INC_W(GEN_IW)) u_gen (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (gen_inc),
            .clr   (gen_clr),
            .cnt   (cnt_flat[(2*c)*CNT_W +: CNT_W]),
            .ovf   (ovf_flat[2*c])
        );

        rxd_sat_counter #(.CNT_W(CNT_W), .INC_W(EAR_IW)) u_ear (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ear_inc),
            .clr   (ear_clr),
            .cnt   (cnt_flat[(2*c+1)*CNT_W +: CNT_W]),
            .ovf   (ovf_flat[2*c+1])
        );

        // R5: an idle early-discard strobe leaves that counter alone.
        p_ear_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!wred_evt[c] && !ear_clr) |=>
                $stable(cnt_flat[(2*c+1)*CNT_W +: CNT_W]));

        // R8: a nonzero write never disturbs the general counter.
        p_nonzero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data != '0 && misc_evt[c*N_CAUSE +: N_CAUSE] == '0) |=>
                $stable(cnt_flat[(2*c)*CNT_W +: CNT_W]));
    end

    rxd_read_port #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W), .NCTR(NCTR)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_ch    (reg_ch),
        .rd_sel   (reg_sel),
        .cnt_flat (cnt_flat),
        .ovf_flat (ovf_flat),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R1: no read data is presented straight out of reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !rd_valid);
endmodule

// File: tb/rx_drop_tally_tb.sv
// Scoreboard bench: the driver predicts each read, the monitor compares.
module rx_drop_tally_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] misc_evt = '0;
    logic [3:0]  wred_evt = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_ch = '0;
    logic        reg_sel = 1'b0;
    logic [16:0] wr_data = '0;
    logic [16:0] rd_data;
    logic        rd_valid;

    always #4 clk = ~clk; // 125 MHz

    rx_drop_tally u_dut (
        .clk(clk), .rst_n(rst_n), .misc_evt(misc_evt), .wred_evt(wred_evt),
        .rd_en(rd_en), .wr_en(wr_en), .reg_ch(reg_ch), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    typedef struct {
        logic [16:0] val;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   m_cnt [4][2];
    bit   m_ovf [4][2];

    // Monitor: pop and compare each returned read.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9: rd_valid with no read pending, got %h expected none", rd_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rd_data !== e.val) begin
                    errors++;
                    $display("FAIL %s: rd_data=%h expected %h", e.tag, rd_data, e.val);
                end
            end
        end
    end

    // One cycle of stimulus; predicts read data and updates the model.
    task automatic cyc(input logic [15:0] m, input logic [3:0] w,
                       input bit rd, input bit wr, input int ch, input bit sel,
                       input logic [16:0] wd, input string tag);
        misc_evt = m; wred_evt = w; rd_en = rd; wr_en = wr;
        reg_ch = ch[1:0]; reg_sel = sel; wr_data = wd;
        if (rd) begin
            exp_t e;
            e.val = {m_ovf[ch][sel], m_cnt[ch][sel][15:0]};
            e.tag = tag;
            exp_q.push_back(e);
        end
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 2; s++) begin
                int inc;
                int t;
                bit clr;
                bit ov;
                inc = (s == 0) ? $countones(m[c*4 +: 4]) : int'(w[c]);
                clr = wr && (ch == c) && (sel == s) && (wd == 0);
                t   = (clr ? 0 : m_cnt[c][s]) + inc;
                ov  = clr ? 1'b0 : m_ovf[c][s];
                if (t > 65535) begin
                    t = 65535;
                    ov = 1'b1;
                end
                m_cnt[c][s] = t;
                m_ovf[c][s] = ov;
            end
        end
        @(negedge clk);
        misc_evt = '0; wred_evt = '0; rd_en = 0; wr_en = 0;
    endtask

    task automatic rd(input int ch, input bit sel, input string tag);
        cyc('0, '0, 1, 0, ch, sel, '0, tag);
    endtask

    task automatic read_all(input string tag);
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 2; s++) rd(c, s, tag);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 2; s++) begin
                m_cnt[c][s] = 0;
                m_ovf[c][s] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rd_valid=%b expected 0", rd_valid);
        end
        read_all("R1");

        // R4: each drop cause on channel 1, one at a time.
        cyc(16'h0010, '0, 0, 0, 0, 0, '0, "R4");
        cyc(16'h0020, '0, 0, 0, 0, 0, '0, "R4");
        cyc(16'h0040, '0, 0, 0, 0, 0, '0, "R4");
        cyc(16'h0080, '0, 0, 0, 0, 0, '0, "R4");
        rd(1, 0, "R4");
        // R4: several causes at once add their number.
        cyc(16'h00B0, '0, 0, 0, 0, 0, '0, "R4");
        cyc(16'h00F0, '0, 0, 0, 0, 0, '0, "R4");
        rd(1, 0, "R4");
        // R5: early discards on channel 3 only, mixed with general strobes on 0.
        cyc(16'h000F, 4'b1000, 0, 0, 0, 0, '0, "R5");
        cyc(16'h0000, 4'b1000, 0, 0, 0, 0, '0, "R5");
        rd(3, 1, "R5");
        rd(3, 0, "R5");
        rd(0, 1, "R5");
        // R6: all counters read back independently.
        cyc(16'h1000, 4'b0010, 0, 0, 0, 0, '0, "R6");
        read_all("R6");

        // R8: nonzero write leaves the counter unchanged.
        cyc('0, '0, 0, 1, 1, 0, 17'h00001, "R8");
        cyc('0, '0, 0, 1, 3, 1, 17'h10000, "R8");
        rd(1, 0, "R8");
        rd(3, 1, "R8");

        // R7: clear with concurrent events on the same counter.
        cyc(16'h0070, '0, 0, 1, 1, 0, '0, "R7");
        rd(1, 0, "R7");
        rd(0, 0, "R7");
        // R9: read and clear in one cycle returns the pre-clear value.
        cyc('0, '0, 1, 1, 0, 0, '0, "R9");
        rd(0, 0, "R9");

        // R2/R3: fill channel 2 general counter to 65532.
        for (int i = 0; i < 16383; i++) cyc(16'h0F00, '0, 0, 0, 0, 0, '0, "R2");
        rd(2, 0, "R2");
        cyc(16'h0700, '0, 0, 0, 0, 0, '0, "R3");
        rd(2, 0, "R3");          // exactly at top, flag still clear
        cyc(16'h0100, '0, 0, 0, 0, 0, '0, "R3");
        rd(2, 0, "R3");          // one past: holds, flag set
        cyc(16'h0F00, '0, 0, 0, 0, 0, '0, "R2");
        cyc(16'h0F00, '0, 0, 0, 0, 0, '0, "R2");
        rd(2, 0, "R2");
        rd(2, 1, "R6");
        // R7: clear removes count and flag.
        cyc('0, '0, 0, 1, 2, 0, '0, "R7");
        rd(2, 0, "R7");
        cyc(16'h0300, '0, 0, 0, 0, 0, '0, "R7");
        rd(2, 0, "R7");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: %0d reads unanswered, expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule